// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic 24-bit down-counter reached through a small register bus. Software writes a reload value, clears the running count and then sets the run and clock-select bits in the control register. From then on the count falls by one on every system clock. When it steps from one to zero, a sticky "wrapped" flag is set and, if interrupts are enabled, a one-clock interrupt request pulse is raised. On the next clock the count is loaded again from the reload register, so the period is the reload value plus one clock.

The wrapped flag stays set until software reads the control register or writes the current-value register. Two bus qualifiers shape that clear. A privilege qualifier guards every control-register access. A debug qualifier, together with a keep-state input, lets a debugger look at the flag without clearing it. Only the system clock may drive the count, so the clock-select bit must be 1 for counting to take place. Read data is combinational and reflects the register state before the clock edge that ends the access.

Top module: `tick_timer`

## Requirements
- R1: After reset the control register (offset 0x10) reads 0x0000_0004, which is clock-select (bit 2) set and run (bit 0), interrupt enable (bit 1) and wrapped flag (bit 16) clear. The reload register (0x14) and current-value register (0x18) read 0, and tick_irq is low.
- R2: While run and clock-select are both 1, a current value of zero is replaced by the reload value on the next clock, and any other current value falls by one. The sequence therefore repeats every reload+1 clocks.
- R3: The wrapped flag (control bit 16) is set on each clock where the count steps from 1 to 0. It stays set until a privileged read of the control register, which returns 1 and clears it, so an immediately following read returns 0.
- R4: With interrupt enable (control bit 1) at 1, tick_irq is high for exactly one clock, in the cycle after the step from 1 to 0. With interrupt enable at 0, tick_irq stays low while the wrapped flag is still set.
- R5: With clock-select (control bit 2) at 0, the current value holds even when run is 1.
- R6: A write of any data to the current-value register sets the count to 0 and clears the wrapped flag. The next running clock reloads from the reload register and does not set the flag.
- R7: A control read with bus_dbg high and dbg_keep high returns the flag and leaves it set. With dbg_keep low, the same read clears the flag.
- R8: With bus_priv low, a control-register read returns 0 and does not clear the flag, and a control-register write is ignored.
- R9: Unused bits read as zero: control bits other than 0, 1, 2 and 16, and bits 31:24 of the reload and current-value registers. Data written to the current-value register is discarded.
- R10: With a reload value of 0, a counter at zero stays at zero and never sets the flag or raises tick_irq.
- R11: When a control read meets a 1-to-0 step in the same clock, the read returns the old flag value and the flag is set at the end of that clock.
- R12: With run (control bit 0) at 0, the current value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_rd | input | 1 | Read strobe; side effects apply on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| bus_priv | input | 1 | Access is privileged |
| bus_dbg | input | 1 | Access comes from a debugger |
| dbg_keep | input | 1 | Debugger access must not disturb the wrapped flag |
| tick_irq | output | 1 | One-clock interrupt request pulse |

## Verification
A wrong count is visible at once through a current-value read, and it moves the interrupt pulse within one period of reload+1 clocks. A flag that is set, cleared or kept wrongly shows up on the next control read. Because the bench reads the same register twice in a row, it can tell a flag that was never set from one that failed to clear. The bench also lines up control reads, debug reads and current-value writes against the exact clock of the 1-to-0 step, so that a wrong priority changes a read value within two clocks.

// File: rtl/tick_timer_pkg.sv
// Package: tick_timer_pkg
// Shared offsets, control bit positions and reset values for the tick timer.
// Assumes byte offsets on an 8-bit or wider address bus.
package tick_timer_pkg;
    localparam int unsigned OFS_CTRL   = 'h10;
    localparam int unsigned OFS_RELOAD = 'h14;
    localparam int unsigned OFS_CUR    = 'h18;

    localparam int unsigned BIT_RUN  = 0;
    localparam int unsigned BIT_IE   = 1;
    localparam int unsigned BIT_SRC  = 2;
    localparam int unsigned BIT_FLAG = 16;

    localparam logic RST_RUN = 1'b0;
    localparam logic RST_IE  = 1'b0;
    localparam logic RST_SRC = 1'b1;
endpackage

// File: rtl/tick_regs.sv
// Module: tick_regs
// Decodes the register bus, holds the control bits and the reload value,
// and drives the combinational read data. It produces one-clock strobes for
// a current-value write and for a flag-clearing control read.
// Assumes that bus_wr and bus_rd are single-cycle qualified strobes.
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_priv,
    input  logic              bus_dbg,
    input  logic              dbg_keep,
    input  logic              flag,
    input  logic [CNT_W-1:0]  cur,
    output logic              ctrl_en,
    output logic              ctrl_ie,
    output logic              ctrl_src,
    output logic [CNT_W-1:0]  reload,
    output logic              cur_wr,
    output logic              flag_rd_clr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic sel_ctrl;
    logic sel_reload;
    logic sel_cur;
    logic ctrl_ok;

    // Address decode and access qualification.
    always_comb begin
        sel_ctrl    = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_reload  = (bus_addr == ADDR_W'(OFS_RELOAD));
        sel_cur     = (bus_addr == ADDR_W'(OFS_CUR));
        ctrl_ok     = sel_ctrl && bus_priv;
        cur_wr      = bus_wr && sel_cur;
        flag_rd_clr = bus_rd && ctrl_ok && !(bus_dbg && dbg_keep);
    end

    // Control bits: privileged writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= RST_RUN;
            ctrl_ie  <= RST_IE;
            ctrl_src <= RST_SRC;
        end else if (bus_wr && ctrl_ok) begin
            ctrl_en  <= bus_wdata[BIT_RUN];
            ctrl_ie  <= bus_wdata[BIT_IE];
            ctrl_src <= bus_wdata[BIT_SRC];
        end
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (bus_wr && sel_reload) begin
            reload <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read data multiplexer; unused bits stay zero.
    always_comb begin
        bus_rdata = '0;
        if (ctrl_ok) begin
            bus_rdata[BIT_RUN]  = ctrl_en;
            bus_rdata[BIT_IE]   = ctrl_ie;
            bus_rdata[BIT_SRC]  = ctrl_src;
            bus_rdata[BIT_FLAG] = flag;
        end else if (sel_reload) begin
            bus_rdata = DATA_W'(reload);
        end else if (sel_cur) begin
            bus_rdata = DATA_W'(cur);
        end
    end
endmodule

// File: rtl/tick_counter.sv
// Module: tick_counter
// The down-counter. It reloads on zero, decrements otherwise and flags the
// clock on which the count steps from one to zero.
// Assumes run already combines the run bit and the clock-select bit.
module tick_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    input  logic             cur_wr,
    output logic [CNT_W-1:0] cur,
    output logic             hit
);
    // Step event: a running clock with the count at one and no software write.
    always_comb begin
        hit = run && !cur_wr && (cur == CNT_W'(1));
    end

    // Count register: a software write forces zero, otherwise reload or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (cur_wr) begin
            cur <= '0;
        end else if (run) begin
            if (cur == '0) begin
                cur <= reload;
            end else begin
                cur <= cur - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/tick_flag.sv
// Module: tick_flag
// Holds the sticky wrapped flag and produces the interrupt pulse.
// Assumes hit is high for at most one clock in a row. A set beats a clear.
module tick_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ie,
    input  logic clr,
    output logic flag,
    output logic irq
);
    // Sticky flag: the set takes priority over either clear source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // One-clock interrupt request following the step event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= hit && ie;
        end
    end
endmodule

// File: rtl/tick_timer.sv
// Module: tick_timer
// Top of the tick timer: the register bus, a 24-bit periodic down-counter
// and the sticky flag and interrupt logic.
// Assumes a single clock domain and synchronous active-low reset.
module tick_timer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_priv,
    input  logic              bus_dbg,
    input  logic              dbg_keep,
    output logic              tick_irq
);
    logic             ctrl_en;
    logic             ctrl_ie;
    logic             ctrl_src;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cur_q;
    logic             cur_wr;
    logic             flag_rd_clr;
    logic             flag_q;
    logic             hit;
    logic             run;

    // The count advances only with run set and the system clock selected.
    always_comb begin
        run = ctrl_en && ctrl_src;
    end

    tick_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_priv   (bus_priv),
        .bus_dbg    (bus_dbg),
        .dbg_keep   (dbg_keep),
        .flag       (flag_q),
        .cur        (cur_q),
        .ctrl_en    (ctrl_en),
        .ctrl_ie    (ctrl_ie),
        .ctrl_src   (ctrl_src),
        .reload     (reload_q),
        .cur_wr     (cur_wr),
        .flag_rd_clr(flag_rd_clr),
        .bus_rdata  (bus_rdata)
    );

    tick_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .reload(reload_q),
        .cur_wr(cur_wr),
        .cur   (cur_q),
        .hit   (hit)
    );

    tick_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .hit  (hit),
        .ie   (ctrl_ie),
        .clr  (flag_rd_clr || cur_wr),
        .flag (flag_q),
        .irq  (tick_irq)
    );
endmodule

// File: rtl/tick_timer_chk.sv
// Module: tick_timer_chk
// Property checker for tick_timer, attached to it through bind.
// Assumes the internal signal names of tick_timer.
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_priv,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_irq,
    input logic              ctrl_en,
    input logic              ctrl_ie,
    input logic              ctrl_src,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  cur_q,
    input logic              cur_wr,
    input logic              flag_q,
    input logic              hit
);
    AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && ctrl_src && !cur_wr && cur_q == '0) |=> cur_q == $past(reload_q)); // R2
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> flag_q); // R3
    AST_IRQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq); // R4
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_irq) |-> $past(ctrl_ie)); // R4
    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_src && !cur_wr) |=> $stable(cur_q)); // R5
    AST_CUR_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cur_q == '0 && !flag_q)); // R6
    AST_UNPRIV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_priv && bus_addr == ADDR_W'(OFS_CTRL)) |-> bus_rdata == '0); // R8
    AST_ZERO_RELOAD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == '0 && reload_q == '0 && !cur_wr) |=> cur_q == '0); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q); // R11
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !cur_wr) |=> $stable(cur_q)); // R12
endmodule

bind tick_timer tick_timer_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_priv (bus_priv),
    .bus_rdata(bus_rdata),
    .tick_irq (tick_irq),
    .ctrl_en  (ctrl_en),
    .ctrl_ie  (ctrl_ie),
    .ctrl_src (ctrl_src),
    .reload_q (reload_q),
    .cur_q    (cur_q),
    .cur_wr   (cur_wr),
    .flag_q   (flag_q),
    .hit      (hit)
);

// File: tb/tick_timer_test.sv
// Directed bench for tick_timer. Every task starts at a falling edge and
// returns at a falling edge; each bus access spans exactly one rising edge.
module tick_timer_test;
    localparam logic [7:0] A_CTRL = 8'h10;
    localparam logic [7:0] A_REL  = 8'h14;
    localparam logic [7:0] A_CUR  = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_priv = 1'b1;
    logic        bus_dbg = 1'b0;
    logic        dbg_keep = 1'b0;
    logic        tick_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_priv(bus_priv), .bus_dbg(bus_dbg), .dbg_keep(dbg_keep),
        .tick_irq(tick_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic priv = 1'b1);
        bus_addr = a; bus_wdata = d; bus_priv = priv; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d,
                      input logic priv = 1'b1, input logic dbg = 1'b0, input logic keep = 1'b0);
        bus_addr = a; bus_priv = priv; bus_dbg = dbg; dbg_keep = keep; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_priv = 1'b1; bus_dbg = 1'b0; dbg_keep = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Leaves the counter stopped with the wrapped flag set (reload 1).
    task automatic make_flag();
        wr(A_REL, 32'd1);
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h5);
        idle(3);
        wr(A_CTRL, 32'h4);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq after reset", {31'd0, tick_irq}, 32'd0);
        rd(A_CTRL, d); check("R1 control reset", d, 32'h4);
        rd(A_REL, d);  check("R1 reload reset", d, 32'h0);
        rd(A_CUR, d);  check("R1 current reset", d, 32'h0);
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        int rl = 3;
        int pulses = 0;
        wr(A_REL, 32'(rl));
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h7);
        bus_addr = A_CUR; bus_rd = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk); #1;
            check("R2 count sequence", bus_rdata, 32'((rl + 1 - (k % (rl + 1))) % (rl + 1)));
            check("R4 irq pulse position", {31'd0, tick_irq}, 32'((k % (rl + 1)) == 0));
            if (tick_irq) pulses++;
        end
        bus_rd = 1'b0;
        check("R4 irq pulse count", 32'(pulses), 32'd3);
        rd(A_CTRL, d); check("R3 flag read set", d, 32'h10007);
        rd(A_CTRL, d); check("R3 flag read clears", d, 32'h7);
        wr(A_CTRL, 32'h4);
    endtask

    task automatic t_noirq();
        logic [31:0] d;
        int pulses = 0;
        wr(A_REL, 32'd2);
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h5);
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk); #1;
            if (tick_irq) pulses++;
        end
        check("R4 no irq when disabled", 32'(pulses), 32'd0);
        wr(A_CTRL, 32'h4);
        rd(A_CTRL, d); check("R4 flag polled without irq", d, 32'h10004);
    endtask

    task automatic t_srchold();
        logic [31:0] d;
        logic [31:0] first;
        wr(A_REL, 32'd5);
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h5);
        idle(3);
        wr(A_CTRL, 32'h1);
        rd(A_CUR, first); check("R5 value at select off", first, 32'd2);
        idle(5);
        rd(A_CUR, d); check("R5 hold without clock select", d, first);
        rd(A_CTRL, d); check("R5 control readback", d, 32'h1);
        wr(A_CTRL, 32'h4);
    endtask

    task automatic t_enhold();
        logic [31:0] d;
        wr(A_REL, 32'd5);
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h5);
        idle(2);
        wr(A_CTRL, 32'h4);
        rd(A_CUR, d); check("R12 value at run off", d, 32'd3);
        idle(4);
        rd(A_CUR, d); check("R12 hold with run clear", d, 32'd3);
    endtask

    task automatic t_curwrite();
        logic [31:0] d;
        wr(A_CTRL, 32'h5);
        idle(4);
        wr(A_CUR, 32'hABCD);
        rd(A_CUR, d);  check("R6 current write gives zero", d, 32'd0);
        rd(A_CTRL, d); check("R6 flag cleared by current write", d, 32'h5);
        rd(A_CUR, d);  check("R6 reload after current write", d, 32'd4);
        rd(A_CTRL, d); check("R6 reload sets no flag", d, 32'h5);
        wr(A_CTRL, 32'h4);
    endtask

    task automatic t_debug();
        logic [31:0] d;
        make_flag();
        rd(A_CTRL, d, 1'b1, 1'b1, 1'b1); check("R7 debug keep read 1", d, 32'h10004);
        rd(A_CTRL, d, 1'b1, 1'b1, 1'b1); check("R7 debug keep read 2", d, 32'h10004);
        rd(A_CTRL, d, 1'b1, 1'b1, 1'b0); check("R7 debug clearing read", d, 32'h10004);
        rd(A_CTRL, d); check("R7 flag cleared by debug read", d, 32'h4);
    endtask

    task automatic t_unpriv();
        logic [31:0] d;
        make_flag();
        rd(A_CTRL, d, 1'b0); check("R8 unprivileged read zero", d, 32'h0);
        wr(A_CTRL, 32'h7, 1'b0);
        rd(A_CTRL, d); check("R8 write ignored and flag kept", d, 32'h10004);
        rd(A_CTRL, d); check("R8 privileged read clears", d, 32'h4);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(A_REL, 32'hFFFF_FFFF);
        rd(A_REL, d); check("R9 reload upper bits", d, 32'h00FF_FFFF);
        wr(A_CUR, 32'hFFFF_FFFF);
        rd(A_CUR, d); check("R9 current write data discarded", d, 32'h0);
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd(A_CTRL, d); check("R9 control reserved bits", d, 32'h0);
        wr(A_CTRL, 32'h4);
    endtask

    task automatic t_reload_zero();
        logic [31:0] d;
        int pulses = 0;
        wr(A_REL, 32'd0);
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h7);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk); #1;
            if (tick_irq) pulses++;
        end
        check("R10 no irq with zero reload", 32'(pulses), 32'd0);
        rd(A_CUR, d);  check("R10 stays at zero", d, 32'd0);
        rd(A_CTRL, d); check("R10 no flag with zero reload", d, 32'h7);
        wr(A_CTRL, 32'h4);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        wr(A_REL, 32'd3);
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h5);
        idle(3);
        rd(A_CTRL, d); check("R11 read returns old flag", d, 32'h5);
        rd(A_CTRL, d); check("R11 set wins over clear", d, 32'h10005);
        rd(A_CTRL, d); check("R11 later read clears", d, 32'h5);
        wr(A_CTRL, 32'h4);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_periodic();
        t_noirq();
        t_srchold();
        t_enhold();
        t_curwrite();
        t_debug();
        t_unpriv();
        t_reserved();
        t_reload_zero();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule